// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block decides which of several bus masters owns a shared system bus. Every master raises its own request line. It also has a lock line, which ties its current transfer to the one that follows. The arbiter answers with a one-hot grant vector. That vector is registered and is the only statement of ownership. A master may drive the transfer-type lines only while its grant bit is high.

The grant is recomputed only at a clock edge where the slave's wait response is low. At that point the current transfer is finishing, so a new owner can take over cleanly. While a slave stretches a transfer by holding wait high, the grant does not move.

Priority is fixed: the lowest-indexed requesting master wins. When nobody requests, the grant parks on a default master, which is parameterised and defaults to master 0. An owner that holds its lock line high at a completing edge keeps the bus for its next transfer, whatever the other masters request.

Top module: `busgrant_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the grant becomes one-hot on the default master (`gnt_o` = 4'b0001 with the default parameters) after that edge.
- R2: After reset, `gnt_o` always has exactly one bit set.
- R3: At a clock edge where `wait_i` is high, `gnt_o` keeps its value, whatever the requests and locks are.
- R4: At a clock edge where `wait_i` is low and the current owner's lock bit is low, the grant moves to the requesting master with the lowest index (bit i of `req_i` belongs to master i).
- R5: At a clock edge where `wait_i` is low, the owner's lock bit is low and `req_i` is all zero, the grant parks on the default master.
- R6: At a clock edge where `wait_i` is low and the lock bit of the current owner is high, `gnt_o` keeps its value, even if a higher-priority master requests.
- R7: Lock bits of masters that do not own the bus have no effect on the grant decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_MASTERS | Per-master bus request, bit i for master i |
| lock_i | input | N_MASTERS | Per-master lock: current and next transfer stay together |
| wait_i | input | 1 | Slave wait response; high extends the current transfer |
| gnt_o | output | N_MASTERS | Registered one-hot grant, bit i for master i |

## Verification
The bench pushes on four kinds of handover.

A request from a higher-priority master that arrives while a slave is still extending a transfer must not take the bus. A design that ignored wait would hand the bus over in the middle of a transfer. Locked sequences are made to compete with a pending master 0. A design that dropped the owner's lock would let master 0 split the indivisible pair. A design that honoured any master's lock would freeze the grant on a foreign lock.

The bench also covers the idle case and a reset in the middle of a run. A priority encoder without a park default would produce an all-zero or multi-hot grant. A reset path that was missed would leave the last owner granted.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Outcome of the grant update at one clock edge
    typedef enum logic [1:0] {
        DEC_HOLD_WAIT = 2'd0,  // slave still extending the transfer
        DEC_HOLD_LOCK = 2'd1,  // owner tied its next transfer to this one
        DEC_PICK      = 2'd2,  // hand over to the winning requester
        DEC_PARK      = 2'd3   // no requester: fall back to default master
    } arb_dec_e;

    // True when the decision replaces the registered grant
    function automatic logic dec_updates(input arb_dec_e d);
        return (d == DEC_PICK) || (d == DEC_PARK);
    endfunction

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N_MASTERS      = 4,
    parameter int DEFAULT_MASTER = 0
) (
    input  logic [N_MASTERS-1:0] req_i,
    output logic [N_MASTERS-1:0] pick_o,
    output logic                 any_o
);
    localparam logic [N_MASTERS-1:0] DEF_OH =
        {{(N_MASTERS-1){1'b0}}, 1'b1} << DEFAULT_MASTER;

    logic [N_MASTERS-1:0] first;

    // Lowest index wins: a bit survives only if nothing below it requests
    genvar gi;
    generate
        for (gi = 0; gi < N_MASTERS; gi++) begin : g_first
            if (gi == 0) begin : g_top
                assign first[gi] = req_i[gi];
            end else begin : g_rest
                assign first[gi] = req_i[gi] & ~(|req_i[gi-1:0]);
            end
        end
    endgenerate

    assign any_o  = |req_i;
    assign pick_o = any_o ? first : DEF_OH;

endmodule

// File: rtl/arb_lock_ctl.sv
module arb_lock_ctl
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 4
) (
    input  logic [N_MASTERS-1:0] gnt_i,
    input  logic [N_MASTERS-1:0] lock_i,
    input  logic                 wait_i,
    input  logic                 any_req_i,
    output arb_dec_e             dec_o
);
    logic owner_locked;

    // Only the owner's lock bit counts; other masters' locks are masked off
    assign owner_locked = |(lock_i & gnt_i);

    always_comb begin
        if (wait_i)            dec_o = DEC_HOLD_WAIT;
        else if (owner_locked) dec_o = DEC_HOLD_LOCK;
        else if (any_req_i)    dec_o = DEC_PICK;
        else                   dec_o = DEC_PARK;
    end

endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg
    import arb_pkg::*;
#(
    parameter int N_MASTERS      = 4,
    parameter int DEFAULT_MASTER = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  arb_dec_e             dec_i,
    input  logic [N_MASTERS-1:0] pick_i,
    output logic [N_MASTERS-1:0] gnt_o
);
    localparam logic [N_MASTERS-1:0] DEF_OH =
        {{(N_MASTERS-1){1'b0}}, 1'b1} << DEFAULT_MASTER;

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_o <= DEF_OH;
        end else if (dec_updates(dec_i)) begin
            gnt_o <= pick_i;
        end
    end

endmodule

// File: rtl/busgrant_arbiter.sv
module busgrant_arbiter
    import arb_pkg::*;
#(
    parameter int N_MASTERS      = 4,
    parameter int DEFAULT_MASTER = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic [N_MASTERS-1:0] lock_i,
    input  logic                 wait_i,
    output logic [N_MASTERS-1:0] gnt_o
);
    logic [N_MASTERS-1:0] pick;
    logic                 any_req;
    arb_dec_e             dec;

    arb_prio_pick #(
        .N_MASTERS      (N_MASTERS),
        .DEFAULT_MASTER (DEFAULT_MASTER)
    ) u_pick (
        .req_i  (req_i),
        .pick_o (pick),
        .any_o  (any_req)
    );

    arb_lock_ctl #(
        .N_MASTERS (N_MASTERS)
    ) u_lock (
        .gnt_i     (gnt_o),
        .lock_i    (lock_i),
        .wait_i    (wait_i),
        .any_req_i (any_req),
        .dec_o     (dec)
    );

    arb_grant_reg #(
        .N_MASTERS      (N_MASTERS),
        .DEFAULT_MASTER (DEFAULT_MASTER)
    ) u_gnt (
        .clk    (clk),
        .rst    (rst),
        .dec_i  (dec),
        .pick_i (pick),
        .gnt_o  (gnt_o)
    );

endmodule

// File: rtl/busgrant_arbiter_chk.sv
module busgrant_arbiter_chk #(
    parameter int N_MASTERS      = 4,
    parameter int DEFAULT_MASTER = 0
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N_MASTERS-1:0] req_i,
    input logic [N_MASTERS-1:0] lock_i,
    input logic                 wait_i,
    input logic [N_MASTERS-1:0] gnt_o
);
    localparam logic [N_MASTERS-1:0] ONE    = {{(N_MASTERS-1){1'b0}}, 1'b1};
    localparam logic [N_MASTERS-1:0] DEF_OH = ONE << DEFAULT_MASTER;

    logic [N_MASTERS-1:0] lowest_req;
    logic                 own_lock;
    assign lowest_req = req_i & (~req_i + ONE);
    assign own_lock   = |(lock_i & gnt_o);

    AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> gnt_o == DEF_OH);                                   // R1
    AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $countones(gnt_o) == 1);                                           // R2
    AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (rst)
        wait_i |=> $stable(gnt_o));                                        // R3
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (!wait_i && !own_lock && req_i != '0) |=> gnt_o == $past(lowest_req)); // R4
    AST_PARK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!wait_i && !own_lock && req_i == '0) |=> gnt_o == DEF_OH);        // R5
    AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!wait_i && own_lock) |=> $stable(gnt_o));                         // R6

endmodule

bind busgrant_arbiter busgrant_arbiter_chk #(
    .N_MASTERS      (N_MASTERS),
    .DEFAULT_MASTER (DEFAULT_MASTER)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .lock_i (lock_i),
    .wait_i (wait_i),
    .gnt_o  (gnt_o)
);

// File: tb/busgrant_arbiter_tb_top.sv
module busgrant_arbiter_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req_i;
    logic [N-1:0] lock_i;
    logic         wait_i;
    logic [N-1:0] gnt_o;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    int    exp_owner = 0;
    string exp_tag   = "R1";
    bit    started   = 1'b0;
    bit    done      = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    busgrant_arbiter #(.N_MASTERS(N), .DEFAULT_MASTER(0)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .lock_i (lock_i),
        .wait_i (wait_i),
        .gnt_o  (gnt_o)
    );

    // Behavioural reference: owner index updated at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            exp_owner = 0;
            exp_tag   = "R1";
        end else if (wait_i) begin
            exp_tag = "R3";
        end else if (lock_i[exp_owner]) begin
            exp_tag = "R6";
        end else begin
            int nxt;
            nxt = -1;
            for (int k = N - 1; k >= 0; k--) if (req_i[k]) nxt = k;
            if (nxt < 0) begin
                exp_owner = 0;
                exp_tag   = "R5";
            end else begin
                exp_tag   = (lock_i != '0) ? "R7" : "R4";
                exp_owner = nxt;
            end
        end
        started = 1'b1;
    end

    // Compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            logic [N-1:0] exp_gnt;
            int ones;
            exp_gnt = '0;
            exp_gnt[exp_owner] = 1'b1;
            n_checks++;
            if (gnt_o !== exp_gnt) begin
                n_fails++;
                $display("FAIL %s: gnt_o=%b expected %b at cycle %0d",
                         exp_tag, gnt_o, exp_gnt, cycles);
            end
            ones = 0;
            for (int k = 0; k < N; k++) if (gnt_o[k] === 1'b1) ones++;
            n_checks++;
            if (ones != 1) begin
                n_fails++;
                $display("FAIL R2: gnt_o=%b has %0d bits set, expected 1",
                         gnt_o, ones);
            end
        end
    end

    task automatic drive(input logic [N-1:0] r, input logic [N-1:0] l,
                         input logic w, input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            req_i  = r;
            lock_i = l;
            wait_i = w;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fails++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; req_i = '0; lock_i = '0; wait_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(4'b0000, 4'b0000, 1'b0, 3);   // R5 park on master 0
        drive(4'b1010, 4'b0000, 1'b0, 2);   // R4 master 1 wins
        drive(4'b0001, 4'b0000, 1'b1, 4);   // R3 extended transfer holds
        drive(4'b0001, 4'b0000, 1'b0, 2);   // R4 hand over to master 0
        drive(4'b1000, 4'b0000, 1'b0, 2);   // R4 master 3
        drive(4'b0001, 4'b1000, 1'b0, 4);   // R6 owner 3 locked
        drive(4'b0001, 4'b1000, 1'b1, 2);   // R3 locked and waiting
        drive(4'b0001, 4'b0000, 1'b0, 2);   // R4 lock released
        drive(4'b0100, 4'b0000, 1'b0, 2);   // owner 2
        drive(4'b0001, 4'b0011, 1'b0, 2);   // R7 foreign locks ignored
        drive(4'b0000, 4'b0000, 1'b0, 2);   // R5 park again
        drive(4'b0000, 4'b0001, 1'b0, 2);   // R6 parked master 0 locks
        drive(4'b0100, 4'b0000, 1'b0, 2);
        for (int c = 0; c < 3000; c++) begin
            drive(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                  1'($urandom_range(0, 2) == 0), 1);
        end
        drive(4'b1000, 4'b0000, 1'b0, 2);
        rst = 1'b1;                          // R1 reset in the middle of a run
        drive(4'b1000, 4'b1000, 1'b0, 2);
        rst = 1'b0;
        drive(4'b0000, 4'b0000, 1'b0, 3);
        finish_run();
    end

endmodule